// File: doc/BRIEF.md
# Manchester serial word decoder

This block takes one single-ended, bi-phase coded serial line and turns it into 16-bit words. It runs from a local clock that is a fixed whole multiple (12, 16, 20 or 24) of the bit rate. A three-bit-time sync pattern marks the start of each word. The decoder locks its bit timing to the midpoint of that pattern, then follows each mid-bit transition to keep its two sampling points centred in the halves of every bit. It shifts in 16 information bits and a trailing parity bit.

For every finished or abandoned word it gives a one-cycle strobe. With the strobe come the 16-bit word, a type bit and two error flags. The type bit is taken from the sync polarity: high-first means command or status, low-first means data. One flag marks a coding violation and the other a parity failure. A system with redundant buses places one instance on each line.

Top module: `mdec_word_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `word_valid`, `manch_err` and `parity_err` are 0 and `word_data` is 0.
- R2: A sync is one level held 3N/2 clocks followed by the opposite level for 3N/2 clocks, where N is `OVERSAMPLE`. A sync that starts high reports `word_is_cmd`=1. A sync that starts low reports `word_is_cmd`=0.
- R3: A sync is accepted when its first level lasts from 3N/2-N/6 to 3N/2+N/6 clocks (inclusive) and its second level lasts at least 3N/2-N/6 clocks. Any other sync produces no strobe.
- R4: The 16 information bits follow the sync most significant bit first and appear on `word_data[15]` down to `word_data[0]`. A one is sent as high then low, and a zero as low then high.
- R5: The 17th bit is parity. When the ones across the 16 information bits and the parity bit are even in number, the strobe carries `parity_err`=1 and `word_data` still holds the received bits. Otherwise `parity_err`=0.
- R6: A bit whose two halves have the same level ends the word at once with a strobe carrying `manch_err`=1 and `parity_err`=0. A level held longer than 2N clocks inside a word does the same. The decoder then looks for a new sync, and the next correct word decodes normally.
- R7: When the level of the last sync half continues as the first half of bit 15, the longer level that results is not an error.
- R8: Sampling realigns on each mid-bit transition. Words whose bits all last N-1 or N+1 clocks decode without error.
- R9: Each word gives one strobe of exactly one cycle. The error flags are high only during a strobe. `word_data` and `word_is_cmd` keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, N times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Serial bi-phase line, asynchronous to `clk` |
| word_valid | output | 1 | One-cycle strobe for each reported word |
| word_data | output | 16 | Received information bits, MSB first on the line |
| word_is_cmd | output | 1 | 1 = high-first sync (command/status), 0 = data |
| manch_err | output | 1 | Coding violation; the word was abandoned |
| parity_err | output | 1 | Odd-parity check failed |

## Verification
If the phase counter drifts or realigns to the wrong point, the two samples of a bit fall in the same half. This shows up as a `manch_err` strobe within one bit time of the fault, or as bit-shifted data at the end of the word. A wrong sync window either drops a word, which shows as a missing strobe about twenty bit times later, or lets a false pattern through, which shows as an extra strobe. A latched polarity error shows as a wrong `word_is_cmd` on the very next strobe. Parity logic faults show on `parity_err` for words with an even or an odd count of ones.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    // Information bits per word, fixed by the line format.
    localparam int unsigned WORD_W = 16;

    typedef enum logic [1:0] {
        ST_HUNT,   // waiting for the first sync level to end
        ST_SYNC2,  // timing the second sync level
        ST_DATA    // sampling information and parity bits
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              is_cmd;
        logic              manch_err;
        logic              parity_err;
    } word_rpt_t;

    // True when the vector holds an odd count of ones.
    function automatic logic odd_ones(input logic [WORD_W:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/mdec_line_sync.sv
module mdec_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic lvl,
    output logic lvl_prev,
    output logic edge_seen
);
    logic [1:0] meta_q;
    logic       last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            last_q <= 1'b0;
        end else begin
            meta_q <= {meta_q[0], line_in};
            last_q <= meta_q[1];
        end
    end

    assign lvl       = meta_q[1];
    assign lvl_prev  = last_q;
    assign edge_seen = meta_q[1] ^ last_q;
endmodule

// File: rtl/mdec_run_timer.sv
module mdec_run_timer #(
    parameter int unsigned RUN_W   = 6,
    parameter int unsigned RUN_MAX = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_seen,
    output logic [RUN_W-1:0] run
);
    localparam logic [RUN_W-1:0] SAT = RUN_W'(RUN_MAX);

    // Clocks since the last level change; on an edge cycle it holds the
    // length of the level that just ended.
    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (edge_seen)
            run <= RUN_W'(1);
        else if (run != SAT)
            run <= run + RUN_W'(1);
    end
endmodule

// File: rtl/mdec_bit_engine.sv
module mdec_bit_engine
    import mdec_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned RUN_W      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic             lvl_prev,
    input  logic             edge_seen,
    input  logic [RUN_W-1:0] run,
    output logic             rpt_valid,
    output word_rpt_t        rpt
);
    localparam int unsigned N        = OVERSAMPLE;
    localparam int unsigned HALF     = N / 2;
    localparam int unsigned QTR      = N / 4;
    localparam int unsigned QTR3     = (3 * N) / 4;
    localparam int unsigned SYNC_NOM = (3 * N) / 2;
    localparam int unsigned TOL      = N / 6;
    localparam int unsigned SYNC_LO  = SYNC_NOM - TOL;
    localparam int unsigned SYNC_HI  = SYNC_NOM + TOL;
    localparam int unsigned STUCK    = 2 * N;
    localparam int unsigned PH_W     = $clog2(SYNC_NOM + 1);
    localparam int unsigned BIT_W    = $clog2(WORD_W + 2);

    localparam logic [PH_W-1:0]  PH_Q     = PH_W'(QTR);
    localparam logic [PH_W-1:0]  PH_Q3    = PH_W'(QTR3);
    localparam logic [PH_W-1:0]  PH_ALIGN = PH_W'(HALF + 1);
    localparam logic [PH_W-1:0]  PH_WRAP  = PH_W'(N - 1);
    localparam logic [PH_W-1:0]  PH_S_END = PH_W'(SYNC_NOM - 1);
    localparam logic [PH_W-1:0]  PH_S_LO  = PH_W'(SYNC_LO);
    localparam logic [RUN_W-1:0] RUN_LO   = RUN_W'(SYNC_LO);
    localparam logic [RUN_W-1:0] RUN_HI   = RUN_W'(SYNC_HI);
    localparam logic [RUN_W-1:0] RUN_STK  = RUN_W'(STUCK);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W);

    rx_state_e         state_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic              samp_a_q;
    logic              kind_q;
    logic [WORD_W-1:0] shreg_q;

    logic first_ok;
    logic in_window;
    logic halves_same;

    assign first_ok    = edge_seen && (run >= RUN_LO) && (run <= RUN_HI);
    assign in_window   = edge_seen && (ph_q > PH_Q) && (ph_q < PH_Q3);
    assign halves_same = (lvl == samp_a_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HUNT;
            ph_q      <= '0;
            bit_q     <= '0;
            samp_a_q  <= 1'b0;
            kind_q    <= 1'b0;
            shreg_q   <= '0;
            rpt_valid <= 1'b0;
            rpt       <= '0;
        end else begin
            rpt_valid <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    if (first_ok) begin
                        state_q <= ST_SYNC2;
                        kind_q  <= lvl_prev;
                        ph_q    <= PH_W'(1);
                    end
                end
                ST_SYNC2: begin
                    if (edge_seen && (ph_q < PH_S_LO)) begin
                        state_q <= ST_HUNT;
                    end else if (ph_q == PH_S_END) begin
                        state_q <= ST_DATA;
                        ph_q    <= '0;
                        bit_q   <= '0;
                    end else begin
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                ST_DATA: begin
                    if (run > RUN_STK) begin
                        rpt_valid <= 1'b1;
                        rpt       <= '{data: shreg_q, is_cmd: kind_q,
                                       manch_err: 1'b1, parity_err: 1'b0};
                        state_q   <= ST_HUNT;
                    end else begin
                        if (in_window)
                            ph_q <= PH_ALIGN;
                        else if (ph_q == PH_WRAP)
                            ph_q <= '0;
                        else
                            ph_q <= ph_q + PH_W'(1);

                        if (ph_q == PH_Q)
                            samp_a_q <= lvl;

                        if (ph_q == PH_Q3) begin
                            if (halves_same) begin
                                rpt_valid <= 1'b1;
                                rpt       <= '{data: shreg_q, is_cmd: kind_q,
                                               manch_err: 1'b1, parity_err: 1'b0};
                                state_q   <= ST_HUNT;
                            end else if (bit_q == LAST_BIT) begin
                                rpt_valid <= 1'b1;
                                rpt       <= '{data: shreg_q, is_cmd: kind_q,
                                               manch_err: 1'b0,
                                               parity_err: !odd_ones({shreg_q, samp_a_q})};
                                state_q   <= ST_HUNT;
                            end else begin
                                shreg_q <= {shreg_q[WORD_W-2:0], samp_a_q};
                                bit_q   <= bit_q + BIT_W'(1);
                            end
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/mdec_word_rx.sv
module mdec_word_rx
    import mdec_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              word_is_cmd,
    output logic              manch_err,
    output logic              parity_err
);
    localparam int unsigned RUN_MAX = 2 * OVERSAMPLE + 1;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

    logic             lvl;
    logic             lvl_prev;
    logic             edge_seen;
    logic [RUN_W-1:0] run;
    logic             rpt_valid;
    word_rpt_t        rpt;

    mdec_line_sync i_line_sync (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .edge_seen (edge_seen)
    );

    mdec_run_timer #(
        .RUN_W   (RUN_W),
        .RUN_MAX (RUN_MAX)
    ) i_run_timer (
        .clk       (clk),
        .rst       (rst),
        .edge_seen (edge_seen),
        .run       (run)
    );

    mdec_bit_engine #(
        .OVERSAMPLE (OVERSAMPLE),
        .RUN_W      (RUN_W)
    ) i_bit_engine (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .edge_seen (edge_seen),
        .run       (run),
        .rpt_valid (rpt_valid),
        .rpt       (rpt)
    );

    assign word_valid  = rpt_valid;
    assign word_data   = rpt.data;
    assign word_is_cmd = rpt.is_cmd;
    assign manch_err   = rpt_valid & rpt.manch_err;
    assign parity_err  = rpt_valid & rpt.parity_err;
endmodule

// File: rtl/mdec_word_rx_chk.sv
module mdec_word_rx_chk
    import mdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              word_is_cmd,
    input logic              manch_err,
    input logic              parity_err
);
    // R1: reset leaves the outputs quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!word_valid && word_data == '0));

    // R9: a strobe never lasts two cycles
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R9: flags only accompany a strobe
    p_flags_need_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (manch_err || parity_err) |-> word_valid);

    // R9: word and type hold between strobes
    p_data_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> ($stable(word_data) && $stable(word_is_cmd)));

    // R6: an abandoned word never also claims a parity result
    p_err_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !(manch_err && parity_err));
endmodule

bind mdec_word_rx mdec_word_rx_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_is_cmd (word_is_cmd),
    .manch_err   (manch_err),
    .parity_err  (parity_err)
);

// File: tb/test_mdec_word_rx.sv
module test_mdec_word_rx;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        word_is_cmd;
    logic        manch_err;
    logic        parity_err;

    always #10 clk = ~clk;

    mdec_word_rx #(.OVERSAMPLE(N)) i_mdec_word_rx (
        .clk         (clk),
        .rst         (rst),
        .line_in     (line_in),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_is_cmd (word_is_cmd),
        .manch_err   (manch_err),
        .parity_err  (parity_err)
    );

    typedef struct {
        logic [15:0] data;
        logic        cmd;
        logic        merr;
        logic        perr;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   checks = 0;
    int   fails  = 0;
    int   stray  = 0;
    bit   done   = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic expect_word(input logic cmd, input logic [15:0] d,
                               input logic merr, input logic perr, input string req);
        exp_t e;
        e.data = d; e.cmd = cmd; e.merr = merr; e.perr = perr; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic hold(input logic lv, input int n);
        line_in = lv;
        repeat (n) @(negedge clk);
    endtask

    // Gap at the level opposite the first sync half, sync, 16 bits, parity.
    task automatic send_word(input logic cmd, input logic [15:0] d, input bit bad_par,
                             input int s1, input int s2, input int ha, input int hb,
                             input int bad_bit);
        logic p;
        p = (~^d) ^ bad_par;
        hold(~cmd, 2 * N);
        hold(cmd, s1);
        hold(~cmd, s2);
        for (int i = 0; i < 17; i++) begin
            logic b;
            b = (i < 16) ? d[15 - i] : p;
            hold(b, ha);
            hold((i == bad_bit) ? b : ~b, hb);
        end
    endtask

    task automatic send_nominal(input logic cmd, input logic [15:0] d);
        send_word(cmd, d, 1'b0, 3 * N / 2, 3 * N / 2, N / 2, N / 2, -1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected strobe", word_data, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(word_is_cmd == mon_e.cmd, mon_e.req, "type", word_is_cmd, mon_e.cmd);
                    check(manch_err == mon_e.merr, mon_e.req, "manch_err", manch_err, mon_e.merr);
                    check(parity_err == mon_e.perr, mon_e.req, "parity_err", parity_err, mon_e.perr);
                    if (!mon_e.merr)
                        check(word_data == mon_e.data, mon_e.req, "data", word_data, mon_e.data);
                end
            end else if (manch_err || parity_err) begin
                stray++;
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(word_valid == 1'b0, "R1", "valid in reset", word_valid, 0);
        check(word_data == 16'h0, "R1", "data in reset", word_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(word_valid == 1'b0, "R1", "valid after reset", word_valid, 0);
        check(!manch_err && !parity_err, "R1", "flags after reset",
              {manch_err, parity_err}, 0);

        // R2 R4: both sync polarities, MSB-first data
        expect_word(1'b1, 16'hA5C3, 1'b0, 1'b0, "R2");
        send_nominal(1'b1, 16'hA5C3);
        expect_word(1'b0, 16'hDA3C, 1'b0, 1'b0, "R4");
        send_nominal(1'b0, 16'hDA3C);
        expect_word(1'b0, 16'h8001, 1'b0, 1'b0, "R4");
        send_nominal(1'b0, 16'h8001);

        // R7: last sync half merges with bit 15's first half
        expect_word(1'b1, 16'h1234, 1'b0, 1'b0, "R7");
        send_nominal(1'b1, 16'h1234);
        expect_word(1'b0, 16'hF00F, 1'b0, 1'b0, "R7");
        send_nominal(1'b0, 16'hF00F);
        expect_word(1'b1, 16'h0000, 1'b0, 1'b0, "R7");
        send_nominal(1'b1, 16'h0000);
        expect_word(1'b0, 16'hFFFF, 1'b0, 1'b0, "R4");
        send_nominal(1'b0, 16'hFFFF);

        // R5: flipped parity on words with even and odd counts of ones
        expect_word(1'b1, 16'h00FF, 1'b0, 1'b1, "R5");
        send_word(1'b1, 16'h00FF, 1'b1, 24, 24, 8, 8, -1);
        expect_word(1'b0, 16'h0007, 1'b0, 1'b1, "R5");
        send_word(1'b0, 16'h0007, 1'b1, 24, 24, 8, 8, -1);

        // R6: matching halves in a data bit, in the parity bit, then recovery
        expect_word(1'b0, 16'h3C3C, 1'b1, 1'b0, "R6");
        send_word(1'b0, 16'h3C3C, 1'b0, 24, 24, 8, 8, 5);
        expect_word(1'b1, 16'h9999, 1'b1, 1'b0, "R6");
        send_word(1'b1, 16'h9999, 1'b0, 24, 24, 8, 8, 16);
        expect_word(1'b1, 16'h6E21, 1'b0, 1'b0, "R6");
        send_nominal(1'b1, 16'h6E21);

        // R6: line stops toggling after the sync
        expect_word(1'b1, 16'h0000, 1'b1, 1'b0, "R6");
        hold(1'b0, 2 * N);
        hold(1'b1, 24);
        hold(1'b0, 3 * N);

        // R3: sync window edges (22..26 accepted for N=16)
        expect_word(1'b1, 16'h8421, 1'b0, 1'b0, "R3");
        send_word(1'b1, 16'h8421, 1'b0, 22, 24, 8, 8, -1);
        expect_word(1'b1, 16'h8C21, 1'b0, 1'b0, "R3");
        send_word(1'b1, 16'h8C21, 1'b0, 26, 24, 8, 8, -1);
        send_word(1'b1, 16'h8421, 1'b0, 21, 24, 8, 8, -1);   // R3 reject: short first half
        send_word(1'b1, 16'h8421, 1'b0, 27, 24, 8, 8, -1);   // R3 reject: long first half
        send_word(1'b1, 16'h8421, 1'b0, 24, 21, 8, 8, -1);   // R3 reject: short second half
        expect_word(1'b0, 16'h4B1D, 1'b0, 1'b0, "R3");
        send_nominal(1'b0, 16'h4B1D);

        // R8: bit period N+1 and N-1
        expect_word(1'b1, 16'hC3A5, 1'b0, 1'b0, "R8");
        send_word(1'b1, 16'hC3A5, 1'b0, 25, 25, 9, 8, -1);
        expect_word(1'b0, 16'h5AA5, 1'b0, 1'b0, "R8");
        send_word(1'b0, 16'h5AA5, 1'b0, 22, 22, 8, 7, -1);
        expect_word(1'b1, 16'h0F0F, 1'b0, 1'b0, "R8");
        send_word(1'b1, 16'h0F0F, 1'b0, 22, 22, 7, 8, -1);

        hold(line_in, 4 * N);

        // R3 R9: every expected word arrived, none extra; flags only with strobes
        check(exp_q.size() == 0, "R3", "words missing", exp_q.size(), 0);
        check(stray == 0, "R9", "flag outside strobe", stray, 0);
        // R9: last word held after the strobe
        check(word_data == 16'h0F0F, "R9", "data hold", word_data, 16'h0F0F);
        check(word_is_cmd == 1'b1, "R9", "type hold", word_is_cmd, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule